// File: doc/BRIEF.md
# Pulse-Coded Isolation Channel Link

This block is a cycle-level digital model of one channel across an isolation barrier. The barrier carries only short pulses, never a steady level. The transmit half turns a level input into pulses on two lines. A rising edge of the input sends a pulse on the set line, and a falling edge sends one on the clear line. While the input stays constant, the transmitter repeats a pulse that matches the present level at a fixed interval. This keeps the far side correct even if a pulse was lost or a false one was picked up.

The receive half is a bistable latch. The set line drives it high and the clear line drives it low, and it holds its state between pulses. A watchdog counts the cycles since the last pulse of either kind. When that count reaches the timeout, the receiver assumes the transmit side is dead. It then drives its output high and raises a failsafe flag. The next pulse of either kind ends the failsafe state.

Between the two halves sits a fault stage. On either line it can block the transmitted pulses or insert extra pulses, so a test can model lost and false pulses. The pulse width, refresh interval and watchdog timeout are set in clock cycles by parameters. The defaults are 1, 100 and 500 cycles, and the timeout must be larger than the refresh interval.

Top module: `pulse_iso_link`

## Requirements
- R1: When `level_in` rises, `tx_set` goes high in the next cycle for PULSE_W cycles, and `tx_clr` stays low. When `level_in` falls, `tx_clr` goes high for PULSE_W cycles, and `tx_set` stays low.
- R2: A pulse on the received line changes `level_out` one clock edge after the line is high: high for the set line, low for the clear line. With no pulse and no watchdog expiry, `level_out` keeps its value.
- R3: If `level_in` has not changed for REFRESH_CYC cycles since the last pulse started, the transmitter sends a pulse of the current level. That is `tx_set` if the level is 1 and `tx_clr` if it is 0. Any input transition restarts this interval.
- R4: If neither received line is high for WD_CYC consecutive clock edges after the last received pulse, `failsafe` goes to 1 and `level_out` goes to 1.
- R5: While `failsafe` is 1, a received pulse clears `failsafe` and applies that pulse's level to `level_out` on the next edge.
- R6: If both received lines are high in the same cycle, the clear wins: `level_out` becomes 0.
- R7: While `rst` is high (synchronous), `level_out` = 1, `failsafe` = 1, and `tx_set` = `tx_clr` = 0. In the first cycle after reset, the transmitter sends a pulse that matches `level_in`.
- R8: A received line is high when its transmitted pulse is present and its drop input is low, or when its inject input is high. The inject input overrides the drop input.
- R9: `tx_set` and `tx_clr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| level_in | input | 1 | Level to carry across the link |
| drop_set | input | 1 | Block transmitted set pulses |
| drop_clr | input | 1 | Block transmitted clear pulses |
| inject_set | input | 1 | Force the received set line high |
| inject_clr | input | 1 | Force the received clear line high |
| tx_set | output | 1 | Transmitted set pulse line (registered) |
| tx_clr | output | 1 | Transmitted clear pulse line (registered) |
| level_out | output | 1 | Received level (registered) |
| failsafe | output | 1 | Watchdog default in force (registered) |

## Verification
The receiver latch could take a wrong value, for example from a false pulse. This is visible at `level_out` one edge after the false pulse. It must be corrected by the next refresh, no later than REFRESH_CYC cycles. A fault in the refresh counter shows up as a refresh pulse at the wrong time on `tx_set`/`tx_clr`, which the bench measures to the exact cycle from the last pulse. A fault in the watchdog counter shows up as `failsafe` rising one edge early or one edge late relative to the WD_CYC boundary. The bench checks `failsafe` on both sides of that boundary.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;

  // Two pulse lines crossing the barrier; bit 1 = set, bit 0 = clear.
  typedef struct packed {
    logic set;
    logic clr;
  } pulse_pair_t;

  localparam int unsigned LANES = 2;

endpackage

// File: rtl/iso_pulse_tx.sv
module iso_pulse_tx
  import iso_link_pkg::*;
#(
  parameter int unsigned PULSE_W     = 1,
  parameter int unsigned REFRESH_CYC = 100
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        level_in,
  output pulse_pair_t pulses
);

  localparam int unsigned PWB = $clog2(PULSE_W + 1);
  localparam int unsigned RFB = $clog2(REFRESH_CYC + 1);
  localparam logic [PWB-1:0] PW_LAST = PWB'(PULSE_W - 1);
  localparam logic [RFB-1:0] RF_LAST = RFB'(REFRESH_CYC - 1);

  logic           last_lvl;
  logic [RFB-1:0] idle_cnt;
  logic [PWB-1:0] width_cnt;
  logic           fire;
  logic           fire_lvl;

  // Pulse request: an input edge takes priority, otherwise the idle refresh.
  always_comb begin
    fire     = 1'b0;
    fire_lvl = last_lvl;
    if (level_in != last_lvl) begin
      fire     = 1'b1;
      fire_lvl = level_in;
    end else if (idle_cnt == RF_LAST) begin
      fire     = 1'b1;
      fire_lvl = last_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_lvl  <= level_in;
      idle_cnt  <= RF_LAST;   // forces a refresh in the first cycle after reset
      width_cnt <= '0;
      pulses    <= '0;
    end else begin
      last_lvl <= level_in;
      if (fire) begin
        idle_cnt   <= '0;
        width_cnt  <= PW_LAST;
        pulses.set <= fire_lvl;
        pulses.clr <= ~fire_lvl;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
        if (width_cnt != '0) begin
          width_cnt <= width_cnt - 1'b1;
        end else begin
          pulses <= '0;
        end
      end
    end
  end

  AST_LINES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pulses.set && pulses.clr)); // R9
  AST_RISE_SENDS_SET: assert property (@(posedge clk) disable iff (rst)
    (level_in && !last_lvl) |=> (pulses.set && !pulses.clr)); // R1
  AST_FALL_SENDS_CLR: assert property (@(posedge clk) disable iff (rst)
    (!level_in && last_lvl) |=> (pulses.clr && !pulses.set)); // R1
  AST_REFRESH_DUE: assert property (@(posedge clk) disable iff (rst)
    (level_in == last_lvl && idle_cnt == RF_LAST) |=> (pulses.set == last_lvl && pulses.clr == !last_lvl)); // R3

endmodule

// File: rtl/iso_fault_stage.sv
module iso_fault_stage
  import iso_link_pkg::*;
(
  input  pulse_pair_t      tx_lines,
  input  logic [LANES-1:0] drop,
  input  logic [LANES-1:0] inject,
  output pulse_pair_t      rx_lines
);

  logic [LANES-1:0] tx_vec;
  logic [LANES-1:0] rx_vec;

  assign tx_vec = tx_lines;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rx_vec[g] = (tx_vec[g] & ~drop[g]) | inject[g];
  end

  assign rx_lines = rx_vec;

endmodule

// File: rtl/iso_pulse_rx.sv
module iso_pulse_rx
  import iso_link_pkg::*;
#(
  parameter int unsigned WD_CYC = 500
) (
  input  logic        clk,
  input  logic        rst,
  input  pulse_pair_t lines,
  output logic        level_out,
  output logic        failsafe
);

  localparam int unsigned WDB = $clog2(WD_CYC + 1);
  localparam logic [WDB-1:0] WD_LAST = WDB'(WD_CYC - 1);

  logic [WDB-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_out <= 1'b1;
      failsafe  <= 1'b1;
      quiet_cnt <= '0;
    end else if (lines.clr) begin      // clear has priority over set
      level_out <= 1'b0;
      failsafe  <= 1'b0;
      quiet_cnt <= '0;
    end else if (lines.set) begin
      level_out <= 1'b1;
      failsafe  <= 1'b0;
      quiet_cnt <= '0;
    end else if (!failsafe) begin
      if (quiet_cnt == WD_LAST) begin
        failsafe  <= 1'b1;
        level_out <= 1'b1;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    lines.clr |=> (!level_out && !failsafe)); // R6
  AST_SET_LEAVES_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (lines.set && !lines.clr) |=> (level_out && !failsafe)); // R5
  AST_DEFAULT_IS_HIGH: assert property (@(posedge clk) disable iff (rst)
    failsafe |-> level_out); // R4
  AST_EXPIRY_NEEDS_SILENCE: assert property (@(posedge clk) disable iff (rst)
    $rose(failsafe) |-> $past(!lines.set && !lines.clr)); // R4
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!lines.set && !lines.clr && !failsafe && quiet_cnt != WD_LAST) |=> $stable(level_out)); // R2

endmodule

// File: rtl/pulse_iso_link.sv
module pulse_iso_link
  import iso_link_pkg::*;
#(
  parameter int unsigned PULSE_W     = 1,
  parameter int unsigned REFRESH_CYC = 100,
  parameter int unsigned WD_CYC      = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  input  logic drop_set,
  input  logic drop_clr,
  input  logic inject_set,
  input  logic inject_clr,
  output logic tx_set,
  output logic tx_clr,
  output logic level_out,
  output logic failsafe
);

  pulse_pair_t tx_lines;
  pulse_pair_t rx_lines;

  iso_pulse_tx #(
    .PULSE_W     (PULSE_W),
    .REFRESH_CYC (REFRESH_CYC)
  ) i_tx (
    .clk      (clk),
    .rst      (rst),
    .level_in (level_in),
    .pulses   (tx_lines)
  );

  iso_fault_stage i_fault (
    .tx_lines (tx_lines),
    .drop     ({drop_set, drop_clr}),
    .inject   ({inject_set, inject_clr}),
    .rx_lines (rx_lines)
  );

  iso_pulse_rx #(
    .WD_CYC (WD_CYC)
  ) i_rx (
    .clk       (clk),
    .rst       (rst),
    .lines     (rx_lines),
    .level_out (level_out),
    .failsafe  (failsafe)
  );

  assign tx_set = tx_lines.set;
  assign tx_clr = tx_lines.clr;

  AST_INJECT_REACHES_RX: assert property (@(posedge clk) disable iff (rst)
    inject_clr |=> (!level_out && !failsafe)); // R8

endmodule

// File: tb/test_pulse_iso_link.sv
module test_pulse_iso_link;

  localparam int unsigned PW = 1;
  localparam int unsigned RF = 100;
  localparam int unsigned WD = 500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic level_in = 1'b0;
  logic drop_set = 1'b0, drop_clr = 1'b0, inject_set = 1'b0, inject_clr = 1'b0;
  logic tx_set, tx_clr, level_out, failsafe;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;   // 50 MHz

  pulse_iso_link #(.PULSE_W(PW), .REFRESH_CYC(RF), .WD_CYC(WD)) i_pulse_iso_link (
    .clk(clk), .rst(rst), .level_in(level_in),
    .drop_set(drop_set), .drop_clr(drop_clr),
    .inject_set(inject_set), .inject_clr(inject_clr),
    .tx_set(tx_set), .tx_clr(tx_clr),
    .level_out(level_out), .failsafe(failsafe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // Ticks until the chosen tx line is high; returns the number of ticks.
  task automatic wait_tx(input bit want_set, input int limit, output int count);
    count = 0;
    for (int i = 0; i < limit; i++) begin
      tick(1);
      count++;
      if (want_set ? tx_set : tx_clr) return;
    end
    count = -1;
  endtask

  task automatic t_reset;
    rst = 1'b1; level_in = 1'b0;
    tick(3);
    check(level_out == 1'b1, "R7", "level_out in reset", level_out, 1);
    check(failsafe == 1'b1, "R7", "failsafe in reset", failsafe, 1);
    check(tx_set == 1'b0 && tx_clr == 1'b0, "R7", "tx lines in reset", {tx_set, tx_clr}, 0);
    rst = 1'b0;
    tick(1);
    check(tx_clr == 1'b1 && tx_set == 1'b0, "R7", "refresh right after reset", {tx_set, tx_clr}, 1);
    tick(1);
    check(level_out == 1'b0, "R2", "level_out after first clear", level_out, 0);
    check(failsafe == 1'b0, "R5", "failsafe left after first pulse", failsafe, 0);
    check(tx_clr == 1'b0, "R1", "pulse width one cycle", tx_clr, 0);
  endtask

  task automatic t_rise_and_refresh;
    int c;
    tick(17);
    level_in = 1'b1;
    tick(1);
    check(tx_set == 1'b1 && tx_clr == 1'b0, "R1", "set pulse on rise", {tx_set, tx_clr}, 2);
    tick(1);
    check(tx_set == 1'b0, "R1", "set pulse width", tx_set, 0);
    check(level_out == 1'b1, "R2", "level_out follows set", level_out, 1);
    wait_tx(1'b1, RF + 5, c);
    check(c == int'(RF) - 1, "R3", "refresh interval after rise", c + 1, RF);
    check(level_out == 1'b1, "R2", "level_out held while idle", level_out, 1);
  endtask

  task automatic t_fall_restarts;
    int c;
    tick(30);
    level_in = 1'b0;
    tick(1);
    check(tx_clr == 1'b1 && tx_set == 1'b0, "R1", "clear pulse on fall", {tx_set, tx_clr}, 1);
    tick(1);
    check(level_out == 1'b0, "R2", "level_out follows clear", level_out, 0);
    wait_tx(1'b0, RF + 5, c);
    check(c == int'(RF) - 1, "R3", "refresh restarted by transition", c + 1, RF);
  endtask

  task automatic t_spurious_set;
    int c;
    tick(5);
    inject_set = 1'b1;
    tick(1);
    inject_set = 1'b0;
    check(level_out == 1'b1, "R8", "injected set reaches receiver", level_out, 1);
    c = 0;
    while (level_out != 1'b0 && c < int'(RF) + 5) begin
      tick(1);
      c++;
    end
    check(level_out == 1'b0, "R3", "refresh corrects false set", level_out, 0);
    check(c <= int'(RF) + 1, "R3", "correction within one interval", c, RF);
  endtask

  task automatic t_watchdog;
    int c;
    drop_set = 1'b1; drop_clr = 1'b1; inject_clr = 1'b1;
    tick(1);
    inject_clr = 1'b0;
    check(level_out == 1'b0 && failsafe == 1'b0, "R8", "inject overrides drop", {level_out, failsafe}, 0);
    tick(WD - 1);
    check(failsafe == 1'b0, "R4", "no expiry one edge early", failsafe, 0);
    check(level_out == 1'b0, "R4", "level held before expiry", level_out, 0);
    tick(1);
    check(failsafe == 1'b1, "R4", "failsafe at timeout", failsafe, 1);
    check(level_out == 1'b1, "R4", "default high at timeout", level_out, 1);
    inject_set = 1'b1;
    tick(1);
    inject_set = 1'b0;
    check(failsafe == 1'b0 && level_out == 1'b1, "R5", "set pulse leaves failsafe", {level_out, failsafe}, 2);
    tick(WD + 2);
    check(failsafe == 1'b1, "R4", "expiry with pulses dropped", failsafe, 1);
    drop_set = 1'b0; drop_clr = 1'b0;
    c = 0;
    while (failsafe != 1'b0 && c < int'(RF) + 5) begin
      tick(1);
      c++;
    end
    check(failsafe == 1'b0 && level_out == 1'b0, "R5", "refresh clear leaves failsafe", {level_out, failsafe}, 0);
  endtask

  task automatic t_clear_wins;
    int c;
    drop_set = 1'b1; drop_clr = 1'b1;
    level_in = 1'b1;
    tick(3);
    inject_set = 1'b1; inject_clr = 1'b1;
    tick(1);
    inject_set = 1'b0; inject_clr = 1'b0;
    check(level_out == 1'b0, "R6", "clear wins over set", level_out, 0);
    drop_set = 1'b0; drop_clr = 1'b0;
    c = 0;
    while (level_out != 1'b1 && c < int'(RF) + 5) begin
      tick(1);
      c++;
      check(!(tx_set && tx_clr), "R9", "tx lines exclusive", {tx_set, tx_clr}, 2);
    end
    check(level_out == 1'b1, "R3", "refresh set restores high", level_out, 1);
  endtask

  initial begin
    t_reset();
    t_rise_and_refresh();
    t_fall_restarts();
    t_spurious_set();
    t_watchdog();
    t_clear_wins();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule